// File: doc/BRIEF.md
# Bus Routing Decoder with Temp Register

This block is the data-movement heart of a processor that has no arithmetic unit. Each cycle, three routing bits of the current micro-instruction select one device to drive the shared 8-bit data bus and one device to latch it. A byte is copied by two micro-instructions in a row. The first has memory drive the bus and loads the temp register. The second has the temp register drive the bus and loads the destination.

The routing field is split into two overlapping 2-bit halves, and each half feeds its own small decoder. The read half picks the bus driver: memory, the temp register, or neither. Its spare code carries the strobe that loads the high address register from the low address bus. The write half picks the destination: the low address register, the temp register, or memory. Code zero in each half means "no strobe". Strobes are registered and active low. Each one covers one full clock cycle, and its destination latches on the rising edge that ends that cycle.

Top module: `bus_route_core`

## Requirements
- R1: While `rst` is high at a rising edge, all six strobes go high, `bus_oe` goes low, `bus_o` goes to zero and the temp register is cleared.
- R2: `route_i` bit 0, bit 1 and bit 2 are the three routing bits of the micro-instruction. The strobes in a cycle reflect the `route_i` value sampled at the rising edge that starts that cycle, and hold for exactly that cycle.
- R3: The read half is `{route_i[1], route_i[0]}`. Code 0 gives no strobe, 1 lowers `mem_rd_n`, 2 lowers `tmp_rd_n` and 3 lowers `hi_ld_n`.
- R4: The write half is `{route_i[2], route_i[1]}`. Code 0 gives no strobe, 1 lowers `lo_ld_n`, 2 lowers `tmp_wr_n` and 3 lowers `mem_wr_n`.
- R5: At most one read-side strobe and at most one write-side strobe is low in any cycle. `mem_rd_n` and `tmp_rd_n` are never low together.
- R6: The temp register takes `bus_i` at the rising edge that ends a cycle with `tmp_wr_n` low. In every other cycle it holds its value.
- R7: `bus_oe` is high exactly in the cycles in which `tmp_rd_n` is low. In those cycles `bus_o` equals the temp register for the whole cycle. In all other cycles `bus_o` is zero.
- R8: A memory-to-temp micro-instruction (route 5) followed directly by a temp-to-memory one (route 6) puts the byte read from memory onto `bus_o` in the second strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| route_i | input | 3 | Routing bits of the current micro-instruction |
| bus_i | input | 8 | Value present on the shared data bus |
| bus_o | output | 8 | Temp register drive value (zero when not driving) |
| bus_oe | output | 1 | High while the temp register drives the bus |
| mem_rd_n | output | 1 | Memory/input drives the bus (active low) |
| tmp_rd_n | output | 1 | Temp register drives the bus (active low) |
| hi_ld_n | output | 1 | Load high address register from low address bus (active low) |
| lo_ld_n | output | 1 | Load low address register from the bus (active low) |
| tmp_wr_n | output | 1 | Load temp register from the bus (active low) |
| mem_wr_n | output | 1 | Write memory from the bus (active low) |

## Verification
The decoder is driven through all eight routing codes in order. This shows that the two halves select their strobes independently and share bit 1 correctly. Directed move sequences are also run: memory to temp to memory, a temp load with no bus driver, and a temp read with no temp load. These tell a correct capture edge apart from an off-by-one latch, and a true hold apart from a spurious reload. A reset in the middle of traffic, followed by a temp read, shows that the stored byte is cleared and not merely hidden. A long pseudo-random stream of codes and bus values then checks bus contention and every output against the reference model on each cycle.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int ROUTE_W = 3;
  localparam int HALF_W  = 2;
  localparam int NCODE   = 1 << HALF_W;

  // read-half codes (code 0 = idle)
  localparam int RD_MEM = 1;
  localparam int RD_TMP = 2;
  localparam int RD_HI  = 3;

  // write-half codes (code 0 = idle)
  localparam int WR_LO  = 1;
  localparam int WR_TMP = 2;
  localparam int WR_MEM = 3;
endpackage

// File: rtl/brc_half_dec.sv
module brc_half_dec #(
  parameter int SEL_W = 2,
  localparam int N = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:1]     strobe_n
);
  logic [N-1:1] hot;

  for (genvar i = 1; i < N; i++) begin : g_code
    assign hot[i] = (sel == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_n <= '1;
    else     strobe_n <= ~hot;
  end
endmodule

// File: rtl/brc_temp_reg.sv
module brc_temp_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              drive_n,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe,
  output logic [DATA_W-1:0] val_q
);
  always_ff @(posedge clk) begin
    if (rst)          val_q <= '0;
    else if (!load_n) val_q <= bus_i;
  end

  assign bus_oe = ~drive_n;
  assign bus_o  = drive_n ? '0 : val_q;
endmodule

// File: rtl/bus_route_core.sv
module bus_route_core
  import brc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ROUTE_W-1:0] route_i,
  input  logic [DATA_W-1:0]  bus_i,
  output logic [DATA_W-1:0]  bus_o,
  output logic               bus_oe,
  output logic               mem_rd_n,
  output logic               tmp_rd_n,
  output logic               hi_ld_n,
  output logic               lo_ld_n,
  output logic               tmp_wr_n,
  output logic               mem_wr_n
);
  logic [NCODE-1:1]  rd_n;
  logic [NCODE-1:1]  wr_n;
  logic [DATA_W-1:0] temp_q;

  // read half: low bits of the routing field
  brc_half_dec #(.SEL_W(HALF_W)) u_rd (
    .clk(clk), .rst(rst),
    .sel(route_i[HALF_W-1:0]),
    .strobe_n(rd_n)
  );

  // write half: high bits, overlapping the read half by one bit
  brc_half_dec #(.SEL_W(HALF_W)) u_wr (
    .clk(clk), .rst(rst),
    .sel(route_i[ROUTE_W-1 -: HALF_W]),
    .strobe_n(wr_n)
  );

  assign mem_rd_n = rd_n[RD_MEM];
  assign tmp_rd_n = rd_n[RD_TMP];
  assign hi_ld_n  = rd_n[RD_HI];
  assign lo_ld_n  = wr_n[WR_LO];
  assign tmp_wr_n = wr_n[WR_TMP];
  assign mem_wr_n = wr_n[WR_MEM];

  brc_temp_reg #(.DATA_W(DATA_W)) u_tmp (
    .clk(clk), .rst(rst),
    .load_n(tmp_wr_n), .drive_n(tmp_rd_n),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
    .val_q(temp_q)
  );
endmodule

// File: rtl/bus_route_chk.sv
module bus_route_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        route_i,
  input logic [DATA_W-1:0] bus_i,
  input logic [DATA_W-1:0] bus_o,
  input logic              bus_oe,
  input logic              mem_rd_n,
  input logic              tmp_rd_n,
  input logic              hi_ld_n,
  input logic              lo_ld_n,
  input logic              tmp_wr_n,
  input logic              mem_wr_n,
  input logic [DATA_W-1:0] temp_q
);
  // R5
  rd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~mem_rd_n, ~tmp_rd_n, ~hi_ld_n}) <= 1);
  // R5
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~lo_ld_n, ~tmp_wr_n, ~mem_wr_n}));
  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_rd_n && bus_oe));
  // R6
  temp_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!tmp_wr_n) |=> (temp_q == $past(bus_i)));
  // R6
  temp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tmp_wr_n) |=> $stable(temp_q));
  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe) |-> (bus_o == '0));
  // R8
  move_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(route_i) == 3'b101) |-> (!mem_rd_n && !tmp_wr_n));
  // R1
  reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (mem_rd_n && tmp_rd_n && hi_ld_n && lo_ld_n && tmp_wr_n
                    && mem_wr_n && !bus_oe));
endmodule

bind bus_route_core bus_route_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .route_i(route_i), .bus_i(bus_i),
  .bus_o(bus_o), .bus_oe(bus_oe),
  .mem_rd_n(mem_rd_n), .tmp_rd_n(tmp_rd_n), .hi_ld_n(hi_ld_n),
  .lo_ld_n(lo_ld_n), .tmp_wr_n(tmp_wr_n), .mem_wr_n(mem_wr_n),
  .temp_q(temp_q)
);

// File: tb/bus_route_core_tb.sv
`timescale 1ns/1ps
module bus_route_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] route_i = 3'd0;
  logic [7:0] bus_i = 8'd0;
  logic [7:0] bus_o;
  logic       bus_oe, mem_rd_n, tmp_rd_n, hi_ld_n, lo_ld_n, tmp_wr_n, mem_wr_n;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  // reference model state
  int   m_rd = 0;
  int   m_wr = 0;
  logic [7:0] m_temp = 8'd0;
  bit   m_rst = 1;

  always #2.5 clk = ~clk;

  bus_route_core u_dut (
    .clk(clk), .rst(rst), .route_i(route_i), .bus_i(bus_i),
    .bus_o(bus_o), .bus_oe(bus_oe),
    .mem_rd_n(mem_rd_n), .tmp_rd_n(tmp_rd_n), .hi_ld_n(hi_ld_n),
    .lo_ld_n(lo_ld_n), .tmp_wr_n(tmp_wr_n), .mem_wr_n(mem_wr_n)
  );

  always @(posedge clk) begin
    started = 1;
    m_rst = rst;
    if (rst) begin
      m_temp = 8'd0; m_rd = 0; m_wr = 0;
    end else begin
      if (m_wr == 2) m_temp = bus_i;
      m_rd = int'(route_i) % 4;
      m_wr = int'(route_i) / 2;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      string rq;
      rq = m_rst ? "R1" : "R3";
      chk(rq, "mem_rd_n", int'(mem_rd_n), int'(m_rd != 1));
      chk(rq, "tmp_rd_n", int'(tmp_rd_n), int'(m_rd != 2));
      chk(rq, "hi_ld_n",  int'(hi_ld_n),  int'(m_rd != 3));
      rq = m_rst ? "R1" : "R4";
      chk(rq, "lo_ld_n",  int'(lo_ld_n),  int'(m_wr != 1));
      chk(rq, "tmp_wr_n", int'(tmp_wr_n), int'(m_wr != 2));
      chk(rq, "mem_wr_n", int'(mem_wr_n), int'(m_wr != 3));
      rq = m_rst ? "R1" : "R7";
      chk(rq, "bus_oe", int'(bus_oe), int'(m_rd == 2));
      chk(rq, "bus_o",  int'(bus_o),  (m_rd == 2) ? int'(m_temp) : 0);
      // R5 contention on every cycle
      chk("R5", "contention", int'(!mem_rd_n && !tmp_rd_n), 0);
    end
  end

  // drive at a negedge, return at the next negedge
  task automatic step(input logic [2:0] r, input logic [7:0] b);
    route_i = r;
    bus_i   = b;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R1", "bus_oe after reset", int'(bus_oe), 0);
    rst = 1'b0;

    // R8 memory -> temp -> memory
    step(3'b101, 8'h00);
    chk("R2", "mem_rd_n one cycle after route", int'(mem_rd_n), 0);
    step(3'b110, 8'hA5);
    chk("R8", "moved byte on bus", int'(bus_o), 8'hA5);
    chk("R8", "mem_wr_n in drive cycle", int'(mem_wr_n), 0);
    step(3'b000, 8'hA5);
    chk("R7", "bus_o idle", int'(bus_o), 0);

    // R6 hold: temp read with low-register load, no temp load
    step(3'b010, 8'h3C);
    step(3'b010, 8'h3C);
    chk("R6", "temp held", int'(bus_o), 8'hA5);

    // R6 temp load with no bus driver, then read
    step(3'b100, 8'h00);
    step(3'b010, 8'h5A);
    chk("R6", "temp loaded", int'(bus_o), 8'h5A);

    // R2 all codes in order
    for (int c = 0; c < 8; c++) step(3'(c), 8'(8'h11 * c));

    // R1 reset mid-stream clears temp
    rst = 1'b1;
    step(3'b011, 8'hFF);
    chk("R1", "tmp_rd_n in reset", int'(tmp_rd_n), 1);
    rst = 1'b0;
    step(3'b010, 8'hFF);
    step(3'b000, 8'hFF);
    chk("R1", "temp cleared", int'(bus_o), 0);

    // pseudo-random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0], lfsr[15:8]);
    end
    step(3'b000, 8'h00);
    finish_run();
  end
endmodule